// File: doc/BRIEF.md
# Single-Cell Protection State Controller

This block is the digital supervisor of a one-cell lithium-ion protector. It runs on a free-running clock. Its inputs are comparator flags that are already digitised: the cell against its overvoltage trip and release levels, the cell against its undervoltage trip and release levels, a discharge overcurrent flag, a charger-present flag and a flag that reports the load has gone. An active-low enable input switches the block on and off.

The controller keeps one of four states. It turns the state into the charge and discharge permissions that drive the pass switch, an enable for the external linear gate loop, a low-power flag, a low-battery warning and a status output that can float. The cell voltage flags are only looked at on a periodic sample tick. A trip needs several tick samples in a row, so short load transients do not cause a trip. Overcurrent is checked on every clock. Once overcurrent trips, the block stays latched until the load is taken away.

Top module: `cp_ctrl`

## Requirements
- R1: After reset, with enable active (en_n low), the state is NORMAL and both charge_ok and dischg_ok are 1. state_o encodes NORMAL=0, OV=1, UV=2, OC=3.
- R2: The sample tick fires once every TICK_CYC clocks. The first tick is on the TICK_CYC-th rising edge after reset is released. The voltage flags (cell_hi, cell_ok_hi, cell_lo, cell_ok_lo) only change the state on a tick edge.
- R3: From NORMAL, the state goes to OV on the DEB_SAMPLES-th tick in a row with cell_hi at 1. A tick with cell_hi at 0 restarts the count. If both voltage faults qualify together, OV wins over UV.
- R4: From NORMAL, the state goes to UV on the DEB_SAMPLES-th tick in a row with cell_lo at 1. A tick with cell_lo at 0 restarts the count.
- R5: In OV, charge_ok is 0, dischg_ok is 1 and loop_en is 1. The state goes back to NORMAL on a tick where cell_ok_hi is 1.
- R6: In UV, dischg_ok is 0 and low_pwr is 1. charge_ok and loop_en are 1 only while chg_det is 1. The state goes back to NORMAL on a tick where cell_ok_lo is 1.
- R7: In NORMAL or OV, if dis_oc is 1 on OC_CYC rising edges in a row, the state goes to OC on the last of those edges. Any shorter burst has no effect. In UV, dis_oc is ignored.
- R8: In OC, charge_ok and dischg_ok are both 0. The state stays in OC until an edge where load_gone is 1, and then goes to NORMAL.
- R9: The status output is disabled (stat_oe=0) in NORMAL and OC. In OV it is driven with stat_lvl=1, and in UV it is driven with stat_lvl=0.
- R10: While enabled, warn_low is 1 exactly when cell_ok_lo is 0.
- R11: With en_n at 1, all outputs except state_o are 0 at once. The next edge forces NORMAL and clears all trip counters.
- R12: If an overcurrent trip and a voltage-fault entry fall on the same edge, the state goes to OC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low block enable |
| cell_hi | input | 1 | Cell above overvoltage trip level |
| cell_ok_hi | input | 1 | Cell below overvoltage release level |
| cell_lo | input | 1 | Cell below undervoltage trip level |
| cell_ok_lo | input | 1 | Cell above undervoltage release level |
| dis_oc | input | 1 | Discharge current above limit |
| chg_det | input | 1 | Charger detected on the pack |
| load_gone | input | 1 | Pack negative pulled close to cell negative |
| charge_ok | output | 1 | Permit charge current |
| dischg_ok | output | 1 | Permit discharge current |
| loop_en | output | 1 | Enable for the linear gate regulation loop |
| low_pwr | output | 1 | Low-power mode flag |
| warn_low | output | 1 | Low-battery warning |
| stat_oe | output | 1 | Status output drive enable |
| stat_lvl | output | 1 | Status output level when driven |
| state_o | output | 2 | Current state code |

## Verification
On every cycle, the assertions check the per-state switch permissions, the status drive, and the disable gating. They also check that each state change had a legal cause on the edge before it: OV entry on a tick with cell_hi set, OC entry after dis_oc, and OC or UV exit only on load_gone or a tick with the release flag set. Only the bench scenarios can show the counting behaviour: that exactly DEB_SAMPLES tick samples, or OC_CYC cycles, are needed, that an interrupted run starts again from zero, when the first tick falls, and that overcurrent wins over an OV entry on the same edge. The bench shows these with a cycle-level model and directed timing cases.

// File: rtl/cp_pkg.sv
package cp_pkg;

  typedef enum logic [1:0] {
    CP_NORMAL = 2'd0,
    CP_OV     = 2'd1,
    CP_UV     = 2'd2,
    CP_OC     = 2'd3
  } cp_state_t;

  // counter width able to hold lim-1 (minimum one bit)
  function automatic int unsigned cp_cnt_w(int unsigned lim);
    return (lim > 1) ? $clog2(lim) : 1;
  endfunction

  // discharge switch path conducts
  function automatic logic cp_dchg_path(cp_state_t s);
    return (s == CP_NORMAL) || (s == CP_OV);
  endfunction

  // charge switch path conducts
  function automatic logic cp_chg_path(cp_state_t s, logic chg);
    return (s == CP_NORMAL) || ((s == CP_UV) && chg);
  endfunction

  // linear gate loop needed in one-direction modes
  function automatic logic cp_loop_on(cp_state_t s, logic chg);
    return (s == CP_OV) || ((s == CP_UV) && chg);
  endfunction

  // {drive enable, level} of the status pin
  function automatic logic [1:0] cp_status(cp_state_t s);
    case (s)
      CP_OV:   return 2'b11;
      CP_UV:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/cp_tick.sv
module cp_tick #(
  parameter int unsigned PERIOD = 600000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import cp_pkg::*;

  localparam int unsigned CW = cp_cnt_w(PERIOD);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cp_persist.sv
module cp_persist #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic flag,
  output logic hit
);
  import cp_pkg::*;

  localparam int unsigned CW = cp_cnt_w(LEN);

  logic [CW-1:0] run;

  // qualifying step that completes the run
  assign hit = step && flag && !clr && (run == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= '0;
    else if (clr)   run <= '0;
    else if (step)  run <= (flag && !hit) ? run + 1'b1 : '0;
  end

endmodule

// File: rtl/cp_ctrl.sv
module cp_ctrl #(
  parameter int unsigned TICK_CYC    = 600000,
  parameter int unsigned OC_CYC      = 17500,
  parameter int unsigned DEB_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_n,
  input  logic       cell_hi,
  input  logic       cell_ok_hi,
  input  logic       cell_lo,
  input  logic       cell_ok_lo,
  input  logic       dis_oc,
  input  logic       chg_det,
  input  logic       load_gone,
  output logic       charge_ok,
  output logic       dischg_ok,
  output logic       loop_en,
  output logic       low_pwr,
  output logic       warn_low,
  output logic       stat_oe,
  output logic       stat_lvl,
  output logic [1:0] state_o
);
  import cp_pkg::*;

  localparam int unsigned NVF = 2;  // voltage fault channels: 0 = over, 1 = under

  cp_state_t st, st_nx;

  logic           en;
  logic           tick;
  logic           path_on;
  logic           oc_hit;
  logic           ov_hit;
  logic           uv_hit;
  logic           vclr;
  logic [NVF-1:0] vflag;
  logic [NVF-1:0] vhit;
  logic [1:0]     stat;

  assign en      = !en_n;
  assign path_on = cp_dchg_path(st);
  assign vclr    = !en || (st != CP_NORMAL);
  assign vflag   = {cell_lo, cell_hi};
  assign ov_hit  = vhit[0];
  assign uv_hit  = vhit[1];

  cp_tick #(.PERIOD(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  // overcurrent persistence, counted every clock while discharge can flow
  cp_persist #(.LEN(OC_CYC)) u_oc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!en || !path_on),
    .step  (1'b1),
    .flag  (dis_oc),
    .hit   (oc_hit)
  );

  // voltage fault debounce, counted on sample ticks
  for (genvar g = 0; g < NVF; g++) begin : g_vdeb
    cp_persist #(.LEN(DEB_SAMPLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (vclr),
      .step  (tick),
      .flag  (vflag[g]),
      .hit   (vhit[g])
    );
  end

  always_comb begin
    st_nx = st;
    if (!en) begin
      st_nx = CP_NORMAL;
    end else begin
      case (st)
        CP_NORMAL: begin
          if (oc_hit)      st_nx = CP_OC;
          else if (ov_hit) st_nx = CP_OV;
          else if (uv_hit) st_nx = CP_UV;
        end
        CP_OV: begin
          if (oc_hit)                  st_nx = CP_OC;
          else if (tick && cell_ok_hi) st_nx = CP_NORMAL;
        end
        CP_UV: begin
          if (tick && cell_ok_lo) st_nx = CP_NORMAL;
        end
        default: begin
          if (load_gone) st_nx = CP_NORMAL;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= CP_NORMAL;
    else        st <= st_nx;
  end

  assign stat      = cp_status(st);
  assign charge_ok = en && cp_chg_path(st, chg_det);
  assign dischg_ok = en && path_on;
  assign loop_en   = en && cp_loop_on(st, chg_det);
  assign low_pwr   = en && (st == CP_UV);
  assign warn_low  = en && !cell_ok_lo;
  assign stat_oe   = en && stat[1];
  assign stat_lvl  = en && stat[0];
  assign state_o   = st;

endmodule

// File: rtl/cp_ctrl_chk.sv
module cp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_n,
  input logic       cell_hi,
  input logic       cell_ok_lo,
  input logic       dis_oc,
  input logic       load_gone,
  input logic       tick,
  input logic [1:0] state,
  input logic       charge_ok,
  input logic       dischg_ok,
  input logic       low_pwr,
  input logic       stat_oe,
  input logic       stat_lvl
);

  assert_oc_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3) |-> (!charge_ok && !dischg_ok));

  assert_ov_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !en_n) |-> (!charge_ok && dischg_ok));

  assert_uv_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && !en_n) |-> (!dischg_ok && low_pwr));

  assert_stat_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 || state == 2'd3) |-> !stat_oe);

  assert_stat_ov_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !en_n) |-> (stat_oe && stat_lvl));

  assert_ov_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && $past(state) == 2'd0) |-> ($past(tick) && $past(cell_hi)));

  assert_oc_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && $past(state) != 2'd3) |-> ($past(dis_oc) && !$past(en_n)));

  assert_oc_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd3 && state != 2'd3) |->
      (state == 2'd0 && ($past(load_gone) || $past(en_n))));

  assert_uv_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd2 && state != 2'd2) |->
      ($past(en_n) || ($past(tick) && $past(cell_ok_lo))));

  assert_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (!charge_ok && !dischg_ok && !stat_oe && !low_pwr));

endmodule

bind cp_ctrl cp_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_n       (en_n),
  .cell_hi    (cell_hi),
  .cell_ok_lo (cell_ok_lo),
  .dis_oc     (dis_oc),
  .load_gone  (load_gone),
  .tick       (tick),
  .state      (st),
  .charge_ok  (charge_ok),
  .dischg_ok  (dischg_ok),
  .low_pwr    (low_pwr),
  .stat_oe    (stat_oe),
  .stat_lvl   (stat_lvl)
);

// File: tb/tb_cp_ctrl.sv
`timescale 1ns/1ps
module tb_cp_ctrl;

  localparam int T   = 8;
  localparam int OCC = 5;
  localparam int D   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b0;
  logic cell_hi = 1'b0, cell_ok_hi = 1'b1, cell_lo = 1'b0, cell_ok_lo = 1'b1;
  logic dis_oc = 1'b0, chg_det = 1'b0, load_gone = 1'b0;
  logic charge_ok, dischg_ok, loop_en, low_pwr, warn_low, stat_oe, stat_lvl;
  logic [1:0] state_o;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  cp_ctrl #(.TICK_CYC(T), .OC_CYC(OCC), .DEB_SAMPLES(D)) dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n),
    .cell_hi(cell_hi), .cell_ok_hi(cell_ok_hi), .cell_lo(cell_lo), .cell_ok_lo(cell_ok_lo),
    .dis_oc(dis_oc), .chg_det(chg_det), .load_gone(load_gone),
    .charge_ok(charge_ok), .dischg_ok(dischg_ok), .loop_en(loop_en), .low_pwr(low_pwr),
    .warn_low(warn_low), .stat_oe(stat_oe), .stat_lvl(stat_lvl), .state_o(state_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cell level in mV mapped onto the four comparator flags
  task automatic set_mv(int mv);
    cell_hi    = (mv > 4250);
    cell_ok_hi = (mv < 3950);
    cell_lo    = (mv < 2350);
    cell_ok_lo = (mv > 2650);
  endtask

  // reference model: 0 NORMAL, 1 OV, 2 UV, 3 OC
  int m_st = 0, m_tc = 0, m_ov = 0, m_uv = 0, m_oc = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tc = 0; m_ov = 0; m_uv = 0; m_oc = 0;
    end else begin
      bit tk, flow, trip;
      int nx;
      tk = (m_tc == T - 1);
      m_tc = tk ? 0 : m_tc + 1;
      if (en_n) begin
        m_st = 0; m_ov = 0; m_uv = 0; m_oc = 0;
      end else begin
        flow = (m_st <= 1);
        trip = flow && dis_oc && (m_oc == OCC - 1);
        nx = m_st;
        if (m_st == 0) begin
          if (trip) nx = 3;
          else if (tk && cell_hi && m_ov == D - 1) nx = 1;
          else if (tk && cell_lo && m_uv == D - 1) nx = 2;
        end else if (m_st == 1) begin
          if (trip) nx = 3;
          else if (tk && cell_ok_hi) nx = 0;
        end else if (m_st == 2) begin
          if (tk && cell_ok_lo) nx = 0;
        end else if (load_gone) nx = 0;
        m_oc = (flow && dis_oc && !trip) ? m_oc + 1 : 0;
        if (m_st == 0 && nx == 0) begin
          if (tk) begin
            m_ov = cell_hi ? m_ov + 1 : 0;
            m_uv = cell_lo ? m_uv + 1 : 0;
          end
        end else begin
          m_ov = 0; m_uv = 0;
        end
        m_st = nx;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    bit on;
    string sw;
    on = !en_n;
    sw = !on ? "R11" : (m_st == 3) ? "R8" : (m_st == 1) ? "R5" : (m_st == 2) ? "R6" : "R1";
    chk((m_st == 1) ? "R3" : (m_st == 2) ? "R4" : (m_st == 3) ? "R7" : "R2", state_o, m_st);
    chk(sw, charge_ok, on && (m_st == 0 || (m_st == 2 && chg_det)));
    chk(sw, dischg_ok, on && m_st < 2);
    chk(on ? "R6" : "R11", loop_en, on && (m_st == 1 || (m_st == 2 && chg_det)));
    chk(on ? "R6" : "R11", low_pwr, on && m_st == 2);
    chk("R10", warn_low, on && !cell_ok_lo);
    chk("R9", stat_oe, on && (m_st == 1 || m_st == 2));
    chk("R9", stat_lvl, on && m_st == 1);
  end

  task automatic do_reset();
    @(posedge clk); #4 rst_n = 1'b0;
    @(posedge clk); #4 rst_n = 1'b1;
  endtask

  initial begin
    #3_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int oc_left;
    void'($urandom(2024));
    set_mv(3800);
    #5;
    @(negedge clk);
    chk("R1", state_o, 0);
    chk("R1", dischg_ok, 1);
    @(posedge clk); #4 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", charge_ok, 1);
    chk("R1", stat_oe, 0);

    // R2 and R3: first tick on edge T, OV after the D-th tick (edge 2T)
    set_mv(4400);
    do_reset();
    repeat (2 * T) @(negedge clk);
    chk("R2", state_o, 0);
    @(negedge clk);
    chk("R3", state_o, 1);
    chk("R5", charge_ok, 0);

    // R12: overcurrent trip lands on the OV entry edge
    set_mv(4400);
    do_reset();
    repeat (2 * T - OCC) @(posedge clk);
    #4 dis_oc = 1'b1;
    repeat (OCC + 1) @(negedge clk);
    chk("R12", state_o, 3);
    chk("R8", dischg_ok, 0);
    repeat (3) @(negedge clk);
    chk("R8", state_o, 3);
    @(posedge clk); #4 en_n = 1'b1;
    @(negedge clk);
    chk("R11", charge_ok + dischg_ok + stat_oe + low_pwr, 0);
    @(negedge clk);
    chk("R11", state_o, 0);
    @(posedge clk); #4 en_n = 1'b0; dis_oc = 1'b0; set_mv(3800);

    // R7: a burst one cycle short does nothing
    @(posedge clk); #4 dis_oc = 1'b1;
    repeat (OCC - 1) begin @(posedge clk); #4; end
    dis_oc = 1'b0;
    @(negedge clk);
    chk("R7", state_o, 0);
    chk("R7", dischg_ok, 1);

    // random segments checked by the model
    oc_left = 0;
    for (int seg = 0; seg < 700; seg++) begin
      int pick, len;
      pick = $urandom % 6;
      case (pick)
        0: set_mv(4400);
        1: set_mv(4100);
        2: set_mv(3800);
        3: set_mv(3000);
        4: set_mv(2500);
        default: set_mv(2200);
      endcase
      chg_det = $urandom % 2;
      en_n = ($urandom % 25 == 0);
      len = 1 + $urandom % 40;
      for (int c = 0; c < len; c++) begin
        @(posedge clk); #4;
        if (oc_left == 0 && ($urandom % 20 == 0)) oc_left = 1 + $urandom % 8;
        dis_oc = (oc_left > 0);
        if (oc_left > 0) oc_left--;
        load_gone = ($urandom % 6 == 0);
      end
    end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule